// File: doc/BRIEF.md
# Prioritized Memory Access Permission Checker

This block decides whether a single memory access may proceed. Each request carries a physical address, a byte count of one, two or four, a single requested permission (read, write or execute) and a flag saying whether the requester runs in machine mode. The region decoder supplies a table of entries. Each entry has an inclusive byte range, an active flag, a lock flag and its own read, write and execute bits. The CSR unit supplies two global security controls: a lockdown bit and a whitelist bit.

The checker tests the first and the last byte of the access against every entry at once. The lowest-numbered active entry that contains either byte decides the result. An access that is only partly inside that entry is refused. Otherwise the allowed set comes from the entry's bits, its lock flag, the requester's mode and the lockdown bit. When no active entry is hit, a default policy applies, and that policy depends on the whitelist and lockdown bits. The grant and the allowed set are registered and appear one clock after the request.

Top module: `pmc_perm_check`

## Requirements
- R1: Entries are searched by rising index. Only active entries (configuration bit 4 set) take part. The lowest-indexed active entry whose inclusive range holds the first or the last byte of the access decides the result, and higher entries are never consulted.
- R2: If the deciding entry holds exactly one of the two end bytes, the access is denied and the allowed set is empty, whatever later entries cover.
- R3: Lockdown clear, machine mode, deciding entry unlocked (configuration bit 3 clear): the allowed set is read+write+execute.
- R4: Lockdown clear, and either a lower mode or a locked entry: the allowed set is the entry's own bits. Configuration bit 2 is read, bit 1 is write and bit 0 is execute. The allowed-set output uses the same order.
- R5: Lockdown set, machine mode: a code is formed from configuration bits [3:0] (lock, read, write, execute). Codes 2, 3 and 14 give read+write. Codes 12 and 15 give read. Codes 11 and 13 give read+execute. Codes 9 and 10 give execute. Every other code gives nothing.
- R6: Lockdown set, lower mode, same code: code 7 gives read+write+execute. Code 5 gives read+execute. Codes 3 and 6 give read+write. Codes 2, 4 and 15 give read. Codes 1, 10 and 11 give execute. Every other code gives nothing.
- R7: No active entry hit and whitelist set: the allowed set is empty and the access is denied, in every mode.
- R8: No hit, whitelist clear, lockdown set: a machine-mode read or write gets read+write. A machine-mode execute and every lower-mode access get nothing.
- R9: No hit, whitelist and lockdown clear: machine mode gets read+write+execute and lower modes get nothing. This also holds when no entry is active.
- R10: The grant is raised only when every requested permission bit is present in the allowed set.
- R11: The response valid, grant and allowed set are registered. The response valid follows the request valid by exactly one clock, and reset clears all three.
- R12: Each request carries exactly one permission bit. The size code 0 means one byte, 1 means two bytes, and 2 or 3 mean four bytes. The last byte is the address plus the size minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Physical address of the first byte |
| req_size | input | 2 | Size code (see R12) |
| req_perm | input | 3 | Requested permission: [2] read, [1] write, [0] execute |
| req_mmode | input | 1 | 1 when the requester runs in machine mode |
| ent_base | input | N_ENT*AW | Per-entry inclusive lower byte address, entry i in slice i |
| ent_limit | input | N_ENT*AW | Per-entry inclusive upper byte address |
| ent_cfg | input | N_ENT*5 | Per-entry {active, lock, read, write, execute} |
| sec_lockdown | input | 1 | Global lockdown control |
| sec_whitelist | input | 1 | Global deny-on-miss control |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access allowed |
| rsp_allow | output | 3 | Allowed set, same bit order as req_perm |

## Verification
Priority selection and partial-overlap refusal can decide the same request. The bench provokes this by overlapping a small read-only entry 0 with a large full-rights entry 1, then sending an access that starts inside entry 0 and ends outside it. The correct result is a plain denial with an empty set. Picking entry 1 or granting read rights both show up at the ports. Back-to-back requests with changing mode and permission also check that each result lands in its own cycle, in order.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int PERM_W = 3;
  localparam int CFG_W  = 5;

  typedef logic [PERM_W-1:0] perm_t;

  localparam perm_t P_NONE = 3'b000;
  localparam perm_t P_R    = 3'b100;
  localparam perm_t P_W    = 3'b010;
  localparam perm_t P_X    = 3'b001;
  localparam perm_t P_RW   = 3'b110;
  localparam perm_t P_RX   = 3'b101;
  localparam perm_t P_ALL  = 3'b111;

  // Offset from the first to the last byte for a size code.
  function automatic int unsigned span_of(input logic [1:0] sz);
    case (sz)
      2'd0:    span_of = 0;
      2'd1:    span_of = 1;
      default: span_of = 3;
    endcase
  endfunction

  // Machine-mode rights under lockdown, code = {lock, r, w, x}.
  function automatic perm_t lock_rights_m(input logic [3:0] code);
    case (code)
      4'd2, 4'd3, 4'd14:  lock_rights_m = P_RW;
      4'd12, 4'd15:       lock_rights_m = P_R;
      4'd11, 4'd13:       lock_rights_m = P_RX;
      4'd9, 4'd10:        lock_rights_m = P_X;
      default:            lock_rights_m = P_NONE;
    endcase
  endfunction

  // Lower-mode rights under lockdown.
  function automatic perm_t lock_rights_u(input logic [3:0] code);
    case (code)
      4'd7:                lock_rights_u = P_ALL;
      4'd5:                lock_rights_u = P_RX;
      4'd3, 4'd6:          lock_rights_u = P_RW;
      4'd2, 4'd4, 4'd15:   lock_rights_u = P_R;
      4'd1, 4'd10, 4'd11:  lock_rights_u = P_X;
      default:             lock_rights_u = P_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pmc_entry_match.sv
module pmc_entry_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  input  logic          active,
  input  logic [AW-1:0] first_b,
  input  logic [AW-1:0] last_b,
  output logic          in_first,
  output logic          in_last
);
  function automatic logic inside_rng(input logic [AW-1:0] a,
                                      input logic [AW-1:0] lo,
                                      input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  assign in_first = active && inside_rng(first_b, base, limit);
  assign in_last  = active && inside_rng(last_b,  base, limit);
endmodule

// File: rtl/pmc_priority_pick.sv
module pmc_priority_pick #(
  parameter int N_ENT = 8,
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0] hit_first,
  input  logic [N_ENT-1:0] hit_last,
  output logic             any_hit,
  output logic [IW-1:0]    sel_idx,
  output logic             straddle
);
  logic [N_ENT-1:0] touch;
  assign touch = hit_first | hit_last;

  always_comb begin
    sel_idx  = '0;
    straddle = 1'b0;
    // Walk downward so the lowest index is written last and wins.
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (touch[i]) begin
        sel_idx  = IW'(i);
        straddle = hit_first[i] ^ hit_last[i];
      end
    end
  end

  assign any_hit = |touch;
endmodule

// File: rtl/pmc_rights.sv
module pmc_rights
  import pmc_pkg::*;
(
  input  logic        matched,
  input  logic        straddle,
  input  logic [3:0]  code,
  input  logic        mmode,
  input  logic        lockdown,
  input  logic        whitelist,
  input  perm_t       want,
  output perm_t       allow,
  output logic        grant
);
  always_comb begin
    allow = P_NONE;
    if (straddle) begin
      allow = P_NONE;
    end else if (matched) begin
      if (!lockdown) begin
        allow = (mmode && !code[3]) ? P_ALL : perm_t'(code[2:0]);
      end else begin
        allow = mmode ? lock_rights_m(code) : lock_rights_u(code);
      end
    end else if (whitelist) begin
      allow = P_NONE;
    end else if (lockdown) begin
      allow = (mmode && !want[0]) ? P_RW : P_NONE;
    end else begin
      allow = mmode ? P_ALL : P_NONE;
    end
  end

  assign grant = !straddle && ((want & ~allow) == P_NONE);
endmodule

// File: rtl/pmc_perm_check.sv
module pmc_perm_check
  import pmc_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int AW    = 32,
  localparam int IW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [AW-1:0]          req_addr,
  input  logic [1:0]             req_size,
  input  logic [2:0]             req_perm,
  input  logic                   req_mmode,
  input  logic [N_ENT*AW-1:0]    ent_base,
  input  logic [N_ENT*AW-1:0]    ent_limit,
  input  logic [N_ENT*CFG_W-1:0] ent_cfg,
  input  logic                   sec_lockdown,
  input  logic                   sec_whitelist,
  output logic                   rsp_valid,
  output logic                   rsp_grant,
  output logic [2:0]             rsp_allow
);
  logic [AW-1:0]    last_b;
  logic [N_ENT-1:0] hit_first, hit_last;
  logic             any_hit, straddle_hit, match_full;
  logic [IW-1:0]    sel_idx;
  logic [CFG_W-1:0] sel_cfg;
  perm_t            allow_next;
  logic             grant_next;

  assign last_b = req_addr + AW'(span_of(req_size));

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    pmc_entry_match #(.AW(AW)) match_i (
      .base     (ent_base[g*AW +: AW]),
      .limit    (ent_limit[g*AW +: AW]),
      .active   (ent_cfg[g*CFG_W + 4]),
      .first_b  (req_addr),
      .last_b   (last_b),
      .in_first (hit_first[g]),
      .in_last  (hit_last[g])
    );
  end

  pmc_priority_pick #(.N_ENT(N_ENT)) pick_i (
    .hit_first (hit_first),
    .hit_last  (hit_last),
    .any_hit   (any_hit),
    .sel_idx   (sel_idx),
    .straddle  (straddle_hit)
  );

  assign sel_cfg    = ent_cfg[sel_idx*CFG_W +: CFG_W];
  assign match_full = any_hit && !straddle_hit;

  pmc_rights rights_i (
    .matched   (match_full),
    .straddle  (straddle_hit),
    .code      (sel_cfg[3:0]),
    .mmode     (req_mmode),
    .lockdown  (sec_lockdown),
    .whitelist (sec_whitelist),
    .want      (req_perm),
    .allow     (allow_next),
    .grant     (grant_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_allow <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= req_valid && grant_next;
      rsp_allow <= req_valid ? allow_next : '0;
    end
  end
endmodule

// File: rtl/pmc_perm_check_sva.sv
module pmc_perm_check_sva #(
  parameter int N_ENT = 8,
  localparam int IW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_perm,
  input logic             sec_whitelist,
  input logic             any_hit,
  input logic             straddle_hit,
  input logic [IW-1:0]    sel_idx,
  input logic [N_ENT-1:0] hit_first,
  input logic [N_ENT-1:0] hit_last,
  input logic             rsp_valid,
  input logic             rsp_grant,
  input logic [2:0]       rsp_allow
);
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r11_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r2_straddle_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && straddle_hit) |=> (!rsp_grant && rsp_allow == 3'b000));

  a_r7_whitelist_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !any_hit && sec_whitelist) |=> (!rsp_grant && rsp_allow == 3'b000));

  a_r10_grant_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant) |-> (($past(req_perm) & ~rsp_allow) == 3'b000));

  a_r12_one_perm: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones(req_perm) == 1));

  a_r1_pick_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (hit_first[sel_idx] || hit_last[sel_idx]));
endmodule

bind pmc_perm_check pmc_perm_check_sva #(.N_ENT(N_ENT)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_perm      (req_perm),
  .sec_whitelist (sec_whitelist),
  .any_hit       (any_hit),
  .straddle_hit  (straddle_hit),
  .sel_idx       (sel_idx),
  .hit_first     (hit_first),
  .hit_last      (hit_last),
  .rsp_valid     (rsp_valid),
  .rsp_grant     (rsp_grant),
  .rsp_allow     (rsp_allow)
);

// File: tb/pmc_perm_check_tb_top.sv
`timescale 1ns/1ps
module pmc_perm_check_tb_top;
  localparam int N  = 8;
  localparam int AW = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic [AW-1:0]  req_addr = '0;
  logic [1:0]     req_size = '0;
  logic [2:0]     req_perm = 3'b100;
  logic           req_mmode = 1'b0;
  logic [N*AW-1:0] ent_base, ent_limit;
  logic [N*5-1:0] ent_cfg;
  logic           sec_lockdown = 1'b0;
  logic           sec_whitelist = 1'b0;
  logic           rsp_valid, rsp_grant;
  logic [2:0]     rsp_allow;

  logic [AW-1:0]  b_arr [N];
  logic [AW-1:0]  l_arr [N];
  logic [4:0]     c_arr [N];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic       grant;
    logic [2:0] allow;
    string      tag;
  } exp_t;
  exp_t sb [$];

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_base[i*AW +: AW] = b_arr[i];
      ent_limit[i*AW +: AW] = l_arr[i];
      ent_cfg[i*5 +: 5] = c_arr[i];
    end
  end

  pmc_perm_check #(.N_ENT(N), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_perm(req_perm), .req_mmode(req_mmode),
    .ent_base(ent_base), .ent_limit(ent_limit), .ent_cfg(ent_cfg),
    .sec_lockdown(sec_lockdown), .sec_whitelist(sec_whitelist),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_allow(rsp_allow)
  );

  // Monitor: pop one expectation per response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && !done) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected response got=%b/%b expected none", rsp_grant, rsp_allow);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rsp_grant !== e.grant || rsp_allow !== e.allow) begin
          fails++;
          $display("FAIL %s got grant=%b allow=%b expected grant=%b allow=%b",
                   e.tag, rsp_grant, rsp_allow, e.grant, e.allow);
        end
      end
    end
  end

  task automatic send(input logic [AW-1:0] a, input logic [1:0] sz, input logic [2:0] p,
                      input logic mm, input logic eg, input logic [2:0] ea, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_perm = p; req_mmode = mm;
    e.grant = eg; e.allow = ea; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic quiet();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [2:0] exp_m(input int c);
    if (c == 14 || c == 2 || c == 3) return 3'b110;
    if (c == 15 || c == 12) return 3'b100;
    if (c == 13 || c == 11) return 3'b101;
    if (c == 10 || c == 9) return 3'b001;
    return 3'b000;
  endfunction

  function automatic logic [2:0] exp_u(input int c);
    if (c == 11 || c == 10 || c == 1) return 3'b001;
    if (c == 15 || c == 4 || c == 2) return 3'b100;
    if (c == 6 || c == 3) return 3'b110;
    if (c == 5) return 3'b101;
    if (c == 7) return 3'b111;
    return 3'b000;
  endfunction

  task automatic finish_up();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      b_arr[i] = '0; l_arr[i] = '0; c_arr[i] = 5'b0;
    end
    repeat (3) @(negedge clk);
    // Reset state (R11)
    checks++;
    if (rsp_valid !== 1'b0 || rsp_grant !== 1'b0 || rsp_allow !== 3'b000) begin
      fails++;
      $display("FAIL R11 reset got %b/%b/%b expected 0/0/000", rsp_valid, rsp_grant, rsp_allow);
    end
    rst_n = 1'b1;

    // R9: no active entry at all
    send(32'h40, 2'd2, 3'b001, 1'b1, 1'b1, 3'b111, "R9 no entries M exec");
    send(32'h40, 2'd0, 3'b100, 1'b0, 1'b0, 3'b000, "R9 no entries lower read");
    quiet();

    // Entry 0: 0x100..0x10F read only; entry 1: 0x100..0x1FF all rights
    b_arr[0] = 32'h100; l_arr[0] = 32'h10F; c_arr[0] = 5'b1_0_100;
    b_arr[1] = 32'h100; l_arr[1] = 32'h1FF; c_arr[1] = 5'b1_0_111;

    send(32'h104, 2'd2, 3'b010, 1'b0, 1'b0, 3'b100, "R1 entry0 wins over entry1");
    send(32'h120, 2'd2, 3'b010, 1'b0, 1'b1, 3'b111, "R1 entry1 beyond entry0");
    send(32'h10E, 2'd2, 3'b100, 1'b0, 1'b0, 3'b000, "R2 straddle size4 denied");
    send(32'h10F, 2'd1, 3'b100, 1'b0, 1'b0, 3'b000, "R2 R12 straddle size2 denied");
    send(32'h10F, 2'd0, 3'b100, 1'b0, 1'b1, 3'b100, "R12 size1 last byte inside");
    send(32'h10C, 2'd3, 3'b100, 1'b0, 1'b1, 3'b100, "R12 size3 as four bytes");
    send(32'h104, 2'd0, 3'b010, 1'b1, 1'b1, 3'b111, "R3 M unlocked full rights");
    send(32'h104, 2'd0, 3'b100, 1'b0, 1'b1, 3'b100, "R4 lower uses entry bits");
    quiet();
    c_arr[0] = 5'b1_1_100;
    send(32'h104, 2'd0, 3'b010, 1'b1, 1'b0, 3'b100, "R4 M locked uses entry bits");
    send(32'h104, 2'd0, 3'b100, 1'b1, 1'b1, 3'b100, "R10 M locked read granted");
    quiet();
    c_arr[0] = 5'b0_1_100;
    send(32'h104, 2'd0, 3'b010, 1'b0, 1'b1, 3'b111, "R1 inactive entry skipped");
    quiet();

    // Lockdown tables via entry 0 code sweep (R5, R6, R10)
    sec_lockdown = 1'b1;
    for (int c = 0; c < 16; c++) begin
      quiet();
      c_arr[0] = {1'b1, 4'(c)};
      send(32'h100, 2'd2, 3'b100, 1'b1, exp_m(c)[2], exp_m(c), $sformatf("R5 M code %0d", c));
      send(32'h100, 2'd2, 3'b001, 1'b0, exp_u(c)[0], exp_u(c), $sformatf("R6 lower code %0d", c));
    end
    quiet();

    // No-match defaults at 0x800
    send(32'h800, 2'd0, 3'b100, 1'b1, 1'b1, 3'b110, "R8 lockdown M read");
    send(32'h800, 2'd0, 3'b010, 1'b1, 1'b1, 3'b110, "R8 lockdown M write");
    send(32'h800, 2'd0, 3'b001, 1'b1, 1'b0, 3'b000, "R8 lockdown M exec");
    send(32'h800, 2'd0, 3'b100, 1'b0, 1'b0, 3'b000, "R8 lockdown lower read");
    quiet();
    sec_whitelist = 1'b1;
    send(32'h800, 2'd0, 3'b100, 1'b1, 1'b0, 3'b000, "R7 whitelist M read");
    send(32'h800, 2'd0, 3'b001, 1'b0, 1'b0, 3'b000, "R7 whitelist lower exec");
    quiet();
    sec_whitelist = 1'b0; sec_lockdown = 1'b0;
    send(32'h800, 2'd0, 3'b001, 1'b1, 1'b1, 3'b111, "R9 default M exec");
    send(32'h800, 2'd0, 3'b010, 1'b0, 1'b0, 3'b000, "R9 default lower write");
    quiet();
    repeat (3) @(negedge clk);

    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R11 missing responses got=%0d pending expected 0", sb.size());
    end
    finish_up();
  end
endmodule